// File: doc/BRIEF.md
# Oscillator Control Register Bank with Interval Timer

This block holds the tuning words of a numerically controlled oscillator. A narrow write port (16-bit data, 3-bit address, active-low select and strobe) fills seven staging registers. Separate active-low transfer requests move staged values into the working registers that the oscillator datapath reads. Each request is registered first, so a new tuning word takes effect on a known clock edge. Software can therefore stage a complete 32-bit word in two halves without the datapath ever seeing a half-updated value.

The block also contains an interval timer. It is an accumulator that adds a programmable increment on every clock. Its registered, active-low carry marks each wrap of the accumulator. The write port is treated as a one-cycle strobe in the main clock domain. The port carries single control writes, so it has no valid/ready handshake and no back-pressure: every qualified write is taken on the edge where it is presented.

Top module: `nco_ctrl_regs`

## Requirements
- R1: Address codes select staging slots: 0 center low half, 1 center high half, 2 offset low half, 3 offset high half, 4 timer-increment low half, 5 timer-increment high half, 6 phase. Each 32-bit working word is {high half, low half}.
- R2: A staging slot is written on a rising edge only when `cs_n` and `we_n` are both 0 at that edge. A write to address code 7 changes no slot.
- R3: A transfer request that is low at edge k is latched at edge k. The working register takes the staging value present at edge k+1, so the new value is visible after edge k+1.
- R4: A working register does not change unless its latched request is active. While the request stays low, the register copies its staging value on every clock.
- R5: On every edge, the timer accumulator becomes (accumulator + working increment) modulo 2^32.
- R6: `tmr_carry_n` is registered. It is 0 for exactly the cycle that follows an edge whose timer addition carried out of bit 31. With increment 0x4000_0000 it is low once in every four cycles.
- R7: A low `tmr_init_n` is latched on one edge. On the next edge the timer adds the old increment to zero instead of to the accumulator, which produces no carry. On that same edge the working increment is loaded from the staging slots.
- R8: After reset, all staging and working registers and the accumulator are 0, and `tmr_carry_n` is 1.
- R9: The phase working register is 16 bits wide and is loaded from slot 6 by `ld_phs_n`, with the R3 timing.
- R10: `ld_tmr_n` loads the working timer increment from {slot 5, slot 4}, with the R3 timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Write select, active low |
| we_n | input | 1 | Write strobe, active low |
| addr | input | 3 | Staging slot code |
| wdata | input | 16 | Write data |
| ld_ctr_n | input | 1 | Transfer request for the center word |
| ld_ofs_n | input | 1 | Transfer request for the offset word |
| ld_tmr_n | input | 1 | Transfer request for the timer increment |
| ld_phs_n | input | 1 | Transfer request for the phase word |
| tmr_init_n | input | 1 | Timer restart and increment load |
| ctr_freq | output | 32 | Working center frequency word |
| ofs_freq | output | 32 | Working offset frequency word |
| phase_ofs | output | 16 | Working phase word |
| tmr_inc | output | 32 | Working timer increment |
| tmr_carry_n | output | 1 | Registered timer carry, active low |

## Verification
Corrupted staging state stays hidden until a transfer request copies it out. It then appears on a working output exactly two edges after the request. For that reason, every write pattern is followed by a transfer, and the outputs are compared on every cycle. A wrong accumulator value shows only through the timing of carry pulses. A single-bit error can therefore take many cycles to move one pulse. The timer is restarted with init and its pulse spacing is counted over a fixed window, which catches both wrong spacing and a pulse in the init cycle.

// File: rtl/nco_regs_pkg.sv
package nco_regs_pkg;
  localparam int ADDR_W  = 3;
  localparam int NUM_STG = 7;
  localparam int SLOT_CTR_LO = 0;
  localparam int SLOT_CTR_HI = 1;
  localparam int SLOT_OFS_LO = 2;
  localparam int SLOT_OFS_HI = 3;
  localparam int SLOT_TMR_LO = 4;
  localparam int SLOT_TMR_HI = 5;
  localparam int SLOT_PHS    = 6;
endpackage

// File: rtl/nco_stage_bank.sv
module nco_stage_bank
  import nco_regs_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            cs_n,
  input  logic                            we_n,
  input  logic [ADDR_W-1:0]               addr,
  input  logic [DATA_W-1:0]               wdata,
  output logic [NUM_STG-1:0][DATA_W-1:0]  stg_q
);
  logic wr_act;
  assign wr_act = ~cs_n & ~we_n;

  for (genvar i = 0; i < NUM_STG; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        stg_q[i] <= '0;
      else if (wr_act && addr == ADDR_W'(i))
        stg_q[i] <= wdata;
    end
  end
endmodule

// File: rtl/nco_xfer_reg.sv
module nco_xfer_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic ld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_q <= 1'b0;
      q    <= '0;
    end else begin
      ld_q <= ~ld_n;
      if (ld_q) q <= d;
    end
  end
endmodule

// File: rtl/nco_timer_acc.sv
module nco_timer_acc #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld_inc_n,
  input  logic         init_n,
  input  logic [W-1:0] inc_d,
  output logic [W-1:0] inc_q,
  output logic         carry_n
);
  logic         ld_q, init_q;
  logic [W-1:0] acc_q, fb;
  logic [W:0]   sum;

  assign fb  = init_q ? '0 : acc_q;
  assign sum = {1'b0, fb} + {1'b0, inc_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_q    <= 1'b0;
      init_q  <= 1'b0;
      acc_q   <= '0;
      inc_q   <= '0;
      carry_n <= 1'b1;
    end else begin
      ld_q    <= ~ld_inc_n;
      init_q  <= ~init_n;
      acc_q   <= sum[W-1:0];
      carry_n <= ~sum[W];
      if (ld_q || init_q) inc_q <= inc_d;
    end
  end
endmodule

// File: rtl/nco_ctrl_regs.sv
module nco_ctrl_regs
  import nco_regs_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cs_n,
  input  logic                we_n,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  input  logic                ld_ctr_n,
  input  logic                ld_ofs_n,
  input  logic                ld_tmr_n,
  input  logic                ld_phs_n,
  input  logic                tmr_init_n,
  output logic [2*DATA_W-1:0] ctr_freq,
  output logic [2*DATA_W-1:0] ofs_freq,
  output logic [DATA_W-1:0]   phase_ofs,
  output logic [2*DATA_W-1:0] tmr_inc,
  output logic                tmr_carry_n
);
  localparam int WORD_W = 2 * DATA_W;

  logic [NUM_STG-1:0][DATA_W-1:0] stg_q;

  nco_stage_bank #(.DATA_W(DATA_W)) u_stage (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n),
    .addr(addr), .wdata(wdata), .stg_q(stg_q)
  );

  nco_xfer_reg #(.W(WORD_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .ld_n(ld_ctr_n),
    .d({stg_q[SLOT_CTR_HI], stg_q[SLOT_CTR_LO]}), .q(ctr_freq)
  );

  nco_xfer_reg #(.W(WORD_W)) u_ofs (
    .clk(clk), .rst_n(rst_n), .ld_n(ld_ofs_n),
    .d({stg_q[SLOT_OFS_HI], stg_q[SLOT_OFS_LO]}), .q(ofs_freq)
  );

  nco_xfer_reg #(.W(DATA_W)) u_phs (
    .clk(clk), .rst_n(rst_n), .ld_n(ld_phs_n),
    .d(stg_q[SLOT_PHS]), .q(phase_ofs)
  );

  nco_timer_acc #(.W(WORD_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .ld_inc_n(ld_tmr_n), .init_n(tmr_init_n),
    .inc_d({stg_q[SLOT_TMR_HI], stg_q[SLOT_TMR_LO]}),
    .inc_q(tmr_inc), .carry_n(tmr_carry_n)
  );
endmodule

// File: rtl/nco_ctrl_regs_chk.sv
module nco_ctrl_regs_chk
  import nco_regs_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        cs_n,
  input logic                        we_n,
  input logic [ADDR_W-1:0]           addr,
  input logic                        ld_ctr_n,
  input logic                        tmr_init_n,
  input logic [2*DATA_W-1:0]         ctr_freq,
  input logic [2*DATA_W-1:0]         ofs_freq,
  input logic [DATA_W-1:0]           phase_ofs,
  input logic [2*DATA_W-1:0]         tmr_inc,
  input logic                        tmr_carry_n,
  input logic [NUM_STG*DATA_W-1:0]   stg_bus
);
  localparam int WORD_W = 2 * DATA_W;

  // R2: no qualified write means staging holds
  p_no_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || we_n || addr == ADDR_W'(NUM_STG)) |=> $stable(stg_bus));

  // R3: request two edges back lands the staged center word
  p_load_ctr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n, 2) && !$past(ld_ctr_n, 2)) |-> ctr_freq == $past(stg_bus[WORD_W-1:0]));

  // R4: no request, no change
  p_hold_ctr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n, 2) && $past(ld_ctr_n, 2)) |-> $stable(ctr_freq));

  // R5: a zero increment can never carry
  p_zero_inc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(tmr_inc) == '0) |-> tmr_carry_n);

  // R7: the restart cycle never carries
  p_init_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n, 2) && !$past(tmr_init_n, 2)) |-> tmr_carry_n);

  // R8: first edge after reset sees cleared state
  p_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (ctr_freq == '0 && ofs_freq == '0 && phase_ofs == '0 &&
                      tmr_inc == '0 && tmr_carry_n && stg_bus == '0));
endmodule

bind nco_ctrl_regs nco_ctrl_regs_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .addr(addr),
  .ld_ctr_n(ld_ctr_n), .tmr_init_n(tmr_init_n),
  .ctr_freq(ctr_freq), .ofs_freq(ofs_freq), .phase_ofs(phase_ofs),
  .tmr_inc(tmr_inc), .tmr_carry_n(tmr_carry_n), .stg_bus(stg_q)
);

// File: tb/nco_ctrl_regs_tb.sv
module nco_ctrl_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, we_n = 1'b1;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic        ld_ctr_n = 1'b1, ld_ofs_n = 1'b1, ld_tmr_n = 1'b1, ld_phs_n = 1'b1;
  logic        tmr_init_n = 1'b1;
  logic [31:0] ctr_freq, ofs_freq, tmr_inc;
  logic [15:0] phase_ofs;
  logic        tmr_carry_n;

  int    n_chk = 0, n_fail = 0;
  bit    cmp_on = 1'b0;
  string cur_req = "R8";

  always #10 clk = ~clk;

  nco_ctrl_regs u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .addr(addr), .wdata(wdata),
    .ld_ctr_n(ld_ctr_n), .ld_ofs_n(ld_ofs_n), .ld_tmr_n(ld_tmr_n), .ld_phs_n(ld_phs_n),
    .tmr_init_n(tmr_init_n), .ctr_freq(ctr_freq), .ofs_freq(ofs_freq),
    .phase_ofs(phase_ofs), .tmr_inc(tmr_inc), .tmr_carry_n(tmr_carry_n)
  );

  // behavioural reference model
  logic [15:0] m_stg [7];
  bit          m_req [5];   // ctr, ofs, tmr, phs, init
  logic [31:0] m_ctr, m_ofs, m_inc, m_acc;
  logic [15:0] m_phs;
  logic        m_cn;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_stg[i]) m_stg[i] = '0;
      foreach (m_req[i]) m_req[i] = 1'b0;
      m_ctr = '0; m_ofs = '0; m_inc = '0; m_acc = '0; m_phs = '0; m_cn = 1'b1;
    end else begin
      longint unsigned s;
      s = (m_req[4] ? 0 : longint'(m_acc)) + longint'(m_inc);
      m_acc = s[31:0];
      m_cn  = ~s[32];
      if (m_req[2] || m_req[4]) m_inc = {m_stg[5], m_stg[4]};
      if (m_req[0]) m_ctr = {m_stg[1], m_stg[0]};
      if (m_req[1]) m_ofs = {m_stg[3], m_stg[2]};
      if (m_req[3]) m_phs = m_stg[6];
      if (!cs_n && !we_n && addr != 3'd7) m_stg[addr] = wdata;
      m_req[0] = !ld_ctr_n; m_req[1] = !ld_ofs_n; m_req[2] = !ld_tmr_n;
      m_req[3] = !ld_phs_n; m_req[4] = !tmr_init_n;
    end
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (cmp_on) begin
    chk(cur_req, "ctr_freq", ctr_freq, m_ctr);
    chk(cur_req, "ofs_freq", ofs_freq, m_ofs);
    chk(cur_req, "phase_ofs", {16'h0, phase_ofs}, {16'h0, m_phs});
    chk(cur_req, "tmr_inc", tmr_inc, m_inc);
    chk(cur_req, "tmr_carry_n", {31'h0, tmr_carry_n}, {31'h0, m_cn});
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d,
                    input logic c = 1'b0, input logic w = 1'b0);
    @(negedge clk);
    cs_n = c; we_n = w; addr = a; wdata = d;
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    cs_n = 1'b1; we_n = 1'b1;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic pulse_all();
    @(negedge clk);
    cs_n = 1'b1; we_n = 1'b1;
    ld_ctr_n = 1'b0; ld_ofs_n = 1'b0; ld_tmr_n = 1'b0; ld_phs_n = 1'b0;
    @(negedge clk);
    ld_ctr_n = 1'b1; ld_ofs_n = 1'b1; ld_tmr_n = 1'b1; ld_phs_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #100000;
    n_fail++;
    $display("FAIL watchdog: actual running expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cur_req = "R8";
    cmp_on = 1'b1;
    @(negedge clk);
    chk("R8", "reset ctr", ctr_freq, 32'h0);
    chk("R8", "reset carry", {31'h0, tmr_carry_n}, 32'h1);

    // R1 / R9 / R10: fill every slot, transfer all
    cur_req = "R1";
    wr(3'd0, 16'h1111); wr(3'd1, 16'h2222); wr(3'd2, 16'h3333); wr(3'd3, 16'h4444);
    wr(3'd4, 16'h0000); wr(3'd5, 16'h0010); wr(3'd6, 16'hBEEF);
    pulse_all();
    chk("R1", "center word", ctr_freq, 32'h2222_1111);
    chk("R1", "offset word", ofs_freq, 32'h4444_3333);
    chk("R9", "phase word", {16'h0, phase_ofs}, 32'h0000_BEEF);
    chk("R10", "timer increment", tmr_inc, 32'h0010_0000);

    // R3: exact latency of one request
    cur_req = "R3";
    wr(3'd0, 16'hA5A5); idle(1);
    ld_ctr_n = 1'b0;
    @(negedge clk); ld_ctr_n = 1'b1;
    chk("R3", "one edge after request", ctr_freq, 32'h2222_1111);
    @(negedge clk);
    chk("R3", "two edges after request", ctr_freq, 32'h2222_A5A5);

    // R4: continuous copy while request held, hold otherwise
    cur_req = "R4";
    @(negedge clk); ld_ofs_n = 1'b0;
    wr(3'd2, 16'h0001); wr(3'd2, 16'h0002); wr(3'd3, 16'h0003);
    idle(3);
    chk("R4", "continuous copy", ofs_freq, 32'h0003_0002);
    ld_ofs_n = 1'b1;
    wr(3'd2, 16'h7777); idle(4);
    chk("R4", "held without request", ofs_freq, 32'h0003_0002);

    // R2: unqualified and reserved writes ignored
    cur_req = "R2";
    wr(3'd0, 16'hDEAD, 1'b1, 1'b0);
    wr(3'd1, 16'hDEAD, 1'b0, 1'b1);
    wr(3'd7, 16'hDEAD);
    wr(3'd6, 16'hDEAD, 1'b1, 1'b1);
    pulse_all();
    chk("R2", "center unchanged", ctr_freq, 32'h2222_A5A5);
    chk("R2", "offset shows staged only", ofs_freq, 32'h0003_7777);
    chk("R2", "phase unchanged", {16'h0, phase_ofs}, 32'h0000_BEEF);
    chk("R2", "timer inc unchanged", tmr_inc, 32'h0010_0000);

    // R7 / R6 / R5: restart timer with quarter-turn increment
    cur_req = "R7";
    wr(3'd4, 16'h0000); wr(3'd5, 16'h4000); idle(1);
    tmr_init_n = 1'b0;
    @(negedge clk); tmr_init_n = 1'b1;
    @(negedge clk);
    chk("R7", "no carry on restart", {31'h0, tmr_carry_n}, 32'h1);
    chk("R7", "increment loaded", tmr_inc, 32'h4000_0000);
    cur_req = "R6";
    begin
      int lows = 0;
      for (int k = 0; k < 16; k++) begin
        @(negedge clk);
        if (!tmr_carry_n) lows++;
      end
      chk("R6", "carries in 16 cycles", lows, 32'd4);
    end
    cur_req = "R5";
    wr(3'd4, 16'h1234); wr(3'd5, 16'h0765); idle(1);
    ld_tmr_n = 1'b0;
    @(negedge clk); ld_tmr_n = 1'b1;
    repeat (300) @(negedge clk);
    chk("R5", "odd increment", tmr_inc, 32'h0765_1234);

    cmp_on = 1'b0;
    finish_run();
  end
endmodule